// File: doc/BRIEF.md
# Operand-Size Resolver and Register Writeback Merge

This block sits at the end of a 64-bit integer pipeline. For each retiring result it works out the effective operand size from the opcode's size class and the prefix flags that came with the instruction. It then folds the result into one of sixteen 64-bit general registers. How the fold works depends on that size. A 32-bit result clears the upper half of the destination. An 8-bit or 16-bit result replaces only its own low lane and leaves every bit above it alone. A 64-bit result replaces the whole register.

Two further write sources share the same path. The first is a 32-bit immediate, which is widened with its sign before the fold. The second is an address-sized update of a pointer or count register, whose width comes from the address size rather than the operand size. The resolved size leaves the block as a registered 2-bit code. A registered read port shows the register contents one cycle after the index is presented.

Top module: `gpr_writeback_unit`

## Requirements
- R1: While `rst` is high at a rising edge, all sixteen registers, `rd_data` and `size_code` become zero.
- R2: A write resolved to 32 bits (size code 2'b10) stores the low 32 bits of the source and forces bits 63:32 of the destination to zero.
- R3: A write resolved to 8 bits (size code 2'b00) replaces bits 7:0 of the destination and leaves bits 63:8 unchanged.
- R4: A write resolved to 16 bits (size code 2'b01) replaces bits 15:0 of the destination and leaves bits 63:16 unchanged.
- R5: For size class 3'd0 (normal), the size is 64 when `pfx_wide` is set, whether or not `pfx_opsz` is also set. Otherwise it is 16 when `pfx_opsz` is set, and 32 with neither flag.
- R6: For size class 3'd1 (default 64), the size is 16 when `pfx_opsz` is set without `pfx_wide`, and 64 in every other case; 32 is never produced.
- R7: Size classes 3'd2 (fixed 16), 3'd3 (fixed 64) and 3'd4 (byte) resolve to 16, 64 and 8 respectively, and both prefix flags have no effect on them.
- R8: With `use_imm` high, the source is `imm_val` sign-extended to 64 bits and `alu_res` is ignored. At size 64 the upper half therefore copies bit 31, and at size 32 it is zero.
- R9: With `addr_upd` high, the size is 32 when `addr_narrow` is set and 64 otherwise, regardless of size class and prefix flags. A 32-bit address update zero-extends into the register.
- R10: With `wr_en` low, no register changes at the clock edge.
- R11: `rd_data` shows the register selected by `rd_idx` one cycle after the edge that samples it. When that register is written at the same edge, `rd_data` returns the value from before the write.
- R12: `size_code` is registered: after each rising edge it holds the size resolved from the inputs present at that edge, encoded 00=8, 01=16, 10=32, 11=64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_class | input | 3 | Opcode size class: 0 normal, 1 default-64, 2 fixed-16, 3 fixed-64, 4 byte |
| pfx_opsz | input | 1 | Operand-size override prefix present |
| pfx_wide | input | 1 | 64-bit width prefix bit present |
| addr_upd | input | 1 | Write is an address-sized pointer/count update |
| addr_narrow | input | 1 | Address size is 32 bits (used with addr_upd) |
| use_imm | input | 1 | Take the source from imm_val instead of alu_res |
| imm_val | input | 32 | Immediate operand |
| alu_res | input | 64 | Result value from the execution unit |
| dst_idx | input | 4 | Destination register index |
| wr_en | input | 1 | Write enable |
| rd_idx | input | 4 | Read port register index |
| rd_data | output | 64 | Registered read data |
| size_code | output | 2 | Registered resolved size code |

## Verification
The merge is tried with destinations preloaded to patterns that have distinct bytes or all ones. The source likewise has non-zero bits above the written lane. This separates a lane-preserving write from a zero-extending one and catches a lane boundary placed one byte off. Size resolution is swept over all four prefix combinations in every class. Only the combined prefix case tells apart which prefix wins, and only the operand-size prefix alone shows whether the default-64 class can reach 32. The immediate path uses immediates with bit 31 set and with it clear, at both 32 and 64 bits. Address updates carry a misleading class and prefix, and a same-edge read and write of one register exposes the read ordering.

// File: rtl/gwb_pkg.sv
package gwb_pkg;
  typedef enum logic [2:0] {
    CLS_NORM  = 3'd0,
    CLS_DEF64 = 3'd1,
    CLS_FIX16 = 3'd2,
    CLS_FIX64 = 3'd3,
    CLS_BYTE  = 3'd4
  } szcls_e;

  typedef enum logic [1:0] {
    SZ8  = 2'b00,
    SZ16 = 2'b01,
    SZ32 = 2'b10,
    SZ64 = 2'b11
  } opsz_e;
endpackage

// File: rtl/opsz_resolve.sv
module opsz_resolve
  import gwb_pkg::*;
(
  input  logic [2:0] cls,
  input  logic       pfx_opsz,
  input  logic       pfx_wide,
  input  logic       addr_upd,
  input  logic       addr_narrow,
  output opsz_e      sz
);
  opsz_e cls_sz;

  // Per-class operand size; unknown class codes behave as normal class.
  always_comb begin
    case (cls)
      CLS_DEF64: cls_sz = (pfx_opsz && !pfx_wide) ? SZ16 : SZ64;
      CLS_FIX16: cls_sz = SZ16;
      CLS_FIX64: cls_sz = SZ64;
      CLS_BYTE:  cls_sz = SZ8;
      default: begin
        if (pfx_wide)      cls_sz = SZ64;
        else if (pfx_opsz) cls_sz = SZ16;
        else               cls_sz = SZ32;
      end
    endcase
  end

  // Address-sized updates take their width from the address size.
  always_comb begin
    if (addr_upd) sz = addr_narrow ? SZ32 : SZ64;
    else          sz = cls_sz;
  end
endmodule

// File: rtl/wb_merge.sv
module wb_merge
  import gwb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int IMMW = 32
) (
  input  opsz_e            sz,
  input  logic             use_imm,
  input  logic [IMMW-1:0]  imm,
  input  logic [XLEN-1:0]  res,
  input  logic [XLEN-1:0]  old,
  output logic [XLEN-1:0]  wdata
);
  localparam int HALF = XLEN / 2;
  localparam logic [XLEN-1:0] ONES = {XLEN{1'b1}};

  logic [XLEN-1:0] src;
  logic [XLEN-1:0] keep;
  logic [XLEN-1:0] low;

  // Immediate widening chosen by the relative widths.
  generate
    if (IMMW < XLEN) begin : g_sext
      assign src = use_imm ? {{(XLEN-IMMW){imm[IMMW-1]}}, imm} : res;
    end else begin : g_full
      assign src = use_imm ? imm[XLEN-1:0] : res;
    end
  endgenerate

  // keep: destination bits that survive; low: source bits that may land.
  always_comb begin
    keep = '0;
    low  = ONES;
    case (sz)
      SZ8:     keep = ONES << 8;
      SZ16:    keep = ONES << 16;
      SZ32:    low  = ONES >> HALF;
      default: ;
    endcase
  end

  assign wdata = (old & keep) | (src & ~keep & low);
endmodule

// File: rtl/gpr_array.sv
module gpr_array #(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [IDXW-1:0] widx,
  input  logic [XLEN-1:0] wdata,
  input  logic [IDXW-1:0] ridx,
  output logic [XLEN-1:0] rdata,
  output logic [XLEN-1:0] dst_old
);
  logic [XLEN-1:0] mem [NREG];

  // Current destination contents feed the merge (read-modify-write).
  assign dst_old = mem[widx];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      rdata <= mem[ridx];
      if (we) mem[widx] <= wdata;
    end
  end
endmodule

// File: rtl/gpr_writeback_unit.sv
module gpr_writeback_unit
  import gwb_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int NREG = 16,
  parameter int IMMW = 32,
  localparam int IDXW = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [2:0]      size_class,
  input  logic            pfx_opsz,
  input  logic            pfx_wide,
  input  logic            addr_upd,
  input  logic            addr_narrow,
  input  logic            use_imm,
  input  logic [IMMW-1:0] imm_val,
  input  logic [XLEN-1:0] alu_res,
  input  logic [IDXW-1:0] dst_idx,
  input  logic            wr_en,
  input  logic [IDXW-1:0] rd_idx,
  output logic [XLEN-1:0] rd_data,
  output logic [1:0]      size_code
);
  opsz_e           sz;
  logic [XLEN-1:0] dst_old;
  logic [XLEN-1:0] wdata;

  opsz_resolve u_res (
    .cls         (size_class),
    .pfx_opsz    (pfx_opsz),
    .pfx_wide    (pfx_wide),
    .addr_upd    (addr_upd),
    .addr_narrow (addr_narrow),
    .sz          (sz)
  );

  wb_merge #(.XLEN(XLEN), .IMMW(IMMW)) u_merge (
    .sz      (sz),
    .use_imm (use_imm),
    .imm     (imm_val),
    .res     (alu_res),
    .old     (dst_old),
    .wdata   (wdata)
  );

  gpr_array #(.XLEN(XLEN), .NREG(NREG)) u_arr (
    .clk     (clk),
    .rst     (rst),
    .we      (wr_en),
    .widx    (dst_idx),
    .wdata   (wdata),
    .ridx    (rd_idx),
    .rdata   (rd_data),
    .dst_old (dst_old)
  );

  always_ff @(posedge clk) begin
    if (rst) size_code <= 2'b00;
    else     size_code <= sz;
  end
endmodule

// File: rtl/gpr_wb_checker.sv
module gpr_wb_checker
  import gwb_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      size_class,
  input logic            pfx_opsz,
  input logic            pfx_wide,
  input logic            addr_upd,
  input logic            wr_en,
  input opsz_e           sz,
  input logic [XLEN-1:0] wdata,
  input logic [XLEN-1:0] dst_old,
  input logic [XLEN-1:0] rd_data,
  input logic [1:0]      size_code
);
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (rd_data == '0 && size_code == 2'b00));

  p_zero_hi_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sz == SZ32) |-> (wdata[XLEN-1:XLEN/2] == '0));

  p_keep_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sz == SZ8) |-> (wdata[XLEN-1:8] == dst_old[XLEN-1:8]));

  p_keep_hi_r4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sz == SZ16) |-> (wdata[XLEN-1:16] == dst_old[XLEN-1:16]));

  p_wide_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (!addr_upd && size_class == 3'd0 && pfx_wide) |-> (sz == SZ64));

  p_no32_r6: assert property (@(posedge clk) disable iff (rst)
    (!addr_upd && size_class == 3'd1) |-> (sz != SZ32));

  p_fixed16_r7: assert property (@(posedge clk) disable iff (rst)
    (!addr_upd && size_class == 3'd2 && (pfx_opsz || pfx_wide)) |-> (sz == SZ16));

  p_size_reg_r12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (size_code == $past(sz)));
endmodule

bind gpr_writeback_unit gpr_wb_checker #(.XLEN(XLEN)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .size_class (size_class),
  .pfx_opsz   (pfx_opsz),
  .pfx_wide   (pfx_wide),
  .addr_upd   (addr_upd),
  .wr_en      (wr_en),
  .sz         (sz),
  .wdata      (wdata),
  .dst_old    (dst_old),
  .rd_data    (rd_data),
  .size_code  (size_code)
);

// File: tb/test_gpr_writeback_unit.sv
module test_gpr_writeback_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  size_class = '0;
  logic        pfx_opsz = 1'b0, pfx_wide = 1'b0;
  logic        addr_upd = 1'b0, addr_narrow = 1'b0, use_imm = 1'b0;
  logic [31:0] imm_val = '0;
  logic [63:0] alu_res = '0;
  logic [3:0]  dst_idx = '0, rd_idx = '0;
  logic        wr_en = 1'b0;
  logic [63:0] rd_data;
  logic [1:0]  size_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gpr_writeback_unit i_gpr_writeback_unit (
    .clk(clk), .rst(rst), .size_class(size_class), .pfx_opsz(pfx_opsz),
    .pfx_wide(pfx_wide), .addr_upd(addr_upd), .addr_narrow(addr_narrow),
    .use_imm(use_imm), .imm_val(imm_val), .alu_res(alu_res),
    .dst_idx(dst_idx), .wr_en(wr_en), .rd_idx(rd_idx),
    .rd_data(rd_data), .size_code(size_code)
  );

  task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check2(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // One clocked operation; returns size_code just after the edge.
  task automatic op(input logic [2:0] cls, input logic p66, input logic pw,
                    input logic au, input logic an, input logic ui,
                    input logic [31:0] imm, input logic [63:0] res,
                    input logic [3:0] idx, input logic we, output logic [1:0] sc);
    @(negedge clk);
    size_class = cls; pfx_opsz = p66; pfx_wide = pw;
    addr_upd = au; addr_narrow = an; use_imm = ui;
    imm_val = imm; alu_res = res; dst_idx = idx; wr_en = we;
    @(posedge clk); #1;
    sc = size_code;
    @(negedge clk);
    wr_en = 1'b0; addr_upd = 1'b0; use_imm = 1'b0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] v);
    @(negedge clk);
    rd_idx = idx;
    @(posedge clk); #1;
    v = rd_data;
  endtask

  task automatic wr64(input logic [3:0] idx, input logic [63:0] v);
    logic [1:0] sc;
    op(3'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, '0, v, idx, 1'b1, sc);
  endtask

  task automatic t_reset();
    logic [63:0] v;
    check2("R1 size_code after reset", size_code, 2'b00);
    for (int i = 0; i < 16; i++) begin
      rd(i[3:0], v);
      check64("R1 register cleared", v, 64'h0);
    end
  endtask

  task automatic t_normal();
    logic [1:0] sc;
    op(3'd0, 0, 0, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R5 normal none", sc, 2'b10);
    op(3'd0, 0, 1, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R5 normal wide", sc, 2'b11);
    op(3'd0, 1, 0, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R5 normal opsz", sc, 2'b01);
    op(3'd0, 1, 1, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R5 normal both", sc, 2'b11);
  endtask

  task automatic t_def64();
    logic [1:0] sc;
    op(3'd1, 0, 0, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R6 def64 none", sc, 2'b11);
    op(3'd1, 1, 0, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R6 def64 opsz", sc, 2'b01);
    op(3'd1, 0, 1, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R6 def64 wide", sc, 2'b11);
    op(3'd1, 1, 1, 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R6 def64 both", sc, 2'b11);
  endtask

  task automatic t_fixed();
    logic [1:0] sc;
    for (int p = 0; p < 4; p++) begin
      op(3'd2, p[0], p[1], 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R7 fixed16", sc, 2'b01);
      op(3'd3, p[0], p[1], 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R7 fixed64", sc, 2'b11);
      op(3'd4, p[0], p[1], 0, 0, 0, '0, '0, 4'd0, 0, sc); check2("R7 byte", sc, 2'b00);
    end
  endtask

  task automatic t_merge();
    logic [1:0] sc;
    logic [63:0] v;
    wr64(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    op(3'd0, 0, 0, 0, 0, 0, '0, 64'h1234_5678_9ABC_DEF0, 4'd3, 1, sc);
    rd(4'd3, v); check64("R2 32-bit zero-extend", v, 64'h0000_0000_9ABC_DEF0);
    wr64(4'd5, 64'h1122_3344_5566_7788);
    op(3'd4, 1, 1, 0, 0, 0, '0, 64'hFFFF_FFFF_FFFF_FFAB, 4'd5, 1, sc);
    rd(4'd5, v); check64("R3 byte keeps upper 56", v, 64'h1122_3344_5566_77AB);
    wr64(4'd6, 64'h1122_3344_5566_7788);
    op(3'd0, 1, 0, 0, 0, 0, '0, 64'hDEAD_BEEF_CAFE_BABE, 4'd6, 1, sc);
    rd(4'd6, v); check64("R4 word keeps upper 48", v, 64'h1122_3344_5566_BABE);
    wr64(4'd6, 64'h0);
    op(3'd0, 0, 1, 0, 0, 0, '0, 64'hDEAD_BEEF_CAFE_BABE, 4'd6, 1, sc);
    rd(4'd6, v); check64("R5 full 64-bit write", v, 64'hDEAD_BEEF_CAFE_BABE);
  endtask

  task automatic t_imm();
    logic [1:0] sc;
    logic [63:0] v;
    op(3'd0, 0, 1, 0, 0, 1, 32'h8000_0001, 64'h5555_5555_5555_5555, 4'd7, 1, sc);
    rd(4'd7, v); check64("R8 imm negative at 64", v, 64'hFFFF_FFFF_8000_0001);
    op(3'd0, 0, 0, 0, 0, 1, 32'h8000_0001, 64'h5555_5555_5555_5555, 4'd7, 1, sc);
    rd(4'd7, v); check64("R8 imm at 32", v, 64'h0000_0000_8000_0001);
    op(3'd1, 0, 0, 0, 0, 1, 32'h7FFF_FFFF, 64'hAAAA_AAAA_AAAA_AAAA, 4'd7, 1, sc);
    rd(4'd7, v); check64("R8 imm positive at 64", v, 64'h0000_0000_7FFF_FFFF);
  endtask

  task automatic t_addr();
    logic [1:0] sc;
    logic [63:0] v;
    wr64(4'd8, 64'hFFFF_FFFF_FFFF_FFFF);
    op(3'd2, 1, 0, 1, 1, 0, '0, 64'hAAAA_BBBB_CCCC_DDDD, 4'd8, 1, sc);
    check2("R9 narrow address size code", sc, 2'b10);
    rd(4'd8, v); check64("R9 narrow address zero-extend", v, 64'h0000_0000_CCCC_DDDD);
    op(3'd4, 1, 0, 1, 0, 0, '0, 64'hAAAA_BBBB_CCCC_DDDD, 4'd8, 1, sc);
    check2("R9 wide address size code", sc, 2'b11);
    rd(4'd8, v); check64("R9 wide address full", v, 64'hAAAA_BBBB_CCCC_DDDD);
  endtask

  task automatic t_noen();
    logic [1:0] sc;
    logic [63:0] v;
    wr64(4'd9, 64'h0123_4567_89AB_CDEF);
    op(3'd3, 0, 0, 0, 0, 0, '0, 64'hFFFF_0000_FFFF_0000, 4'd9, 0, sc);
    rd(4'd9, v); check64("R10 disabled write ignored", v, 64'h0123_4567_89AB_CDEF);
    rd(4'd10, v); check64("R10 neighbour untouched", v, 64'h0);
  endtask

  task automatic t_collide();
    logic [63:0] v;
    @(negedge clk);
    size_class = 3'd3; pfx_opsz = 0; pfx_wide = 0; addr_upd = 0; use_imm = 0;
    alu_res = 64'hCAFE_F00D_1234_5678; dst_idx = 4'd11; wr_en = 1; rd_idx = 4'd11;
    @(posedge clk); #1;
    check64("R11 same-edge read returns old", rd_data, 64'h0);
    @(negedge clk); wr_en = 0;
    @(posedge clk); #1;
    check64("R11 next read returns new", rd_data, 64'hCAFE_F00D_1234_5678);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_normal();
    t_def64();
    t_fixed();
    t_merge();
    t_imm();
    t_addr();
    t_noen();
    t_collide();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule